// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit guards the writes of a 512-byte nonvolatile serial memory. It keeps a write-enable latch and a two-bit block-protect field, and from those, the active-low write-protect pin and the current target address it tells the command logic whether the byte being written may go into the array and whether a status-register write may take effect. The command decoder feeds it one-cycle strobes: set enable, disable, write status (with its data byte) and end of a write command (the chip-select rising edge that closes any write). The status byte it presents for readback carries the protect bits and the latch. There is no busy flag, because every write finishes immediately.

The protect field selects one of four regions: nothing, the top quarter, the top half or the whole array. The protect bits live in plain registers here. The memory permit is combinational, so the command logic can gate each byte at the moment it is complete.

Top module: `wr_guard`

## Requirements
- R1: After reset the latch is 0 and the status byte reads 8'h00. A set-enable strobe sets the latch. A disable strobe clears it.
- R2: An end-of-write strobe clears the latch. It wins over a set-enable or disable strobe in the same cycle. Disable wins over set-enable.
- R3: The status byte is {4'b0000, bp[1], bp[0], latch, 1'b0}. An accepted status write loads only data bits 3:2 into bp. The fixed bits and the latch bit ignore the data. No bit shows a busy state.
- R4: The protect field selects the protected region. bp=00 protects nothing. bp=01 protects 0x180..0x1FF. bp=10 protects 0x100..0x1FF. bp=11 protects 0x000..0x1FF.
- R5: While the latch is 0, mem_wr_ok and sr_wr_ok are both 0, whatever the pin.
- R6: While wp_n is 0, mem_wr_ok and sr_wr_ok are both 0.
- R7: With the latch 1 and wp_n 1, sr_wr_ok is 1. mem_wr_ok is 1 exactly when the address is outside the protected region.
- R8: A status write that is refused leaves bp unchanged. The end-of-write strobe that follows still clears the latch.
- R9: mem_wr_ok follows a change of address or pin in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_set_en | input | 1 | Set-enable command strobe |
| cmd_clr_en | input | 1 | Disable command strobe |
| cmd_wrsr | input | 1 | Status-write strobe, with the byte on sr_wdata |
| sr_wdata | input | 8 | Data byte of a status write |
| cmd_end_wr | input | 1 | Strobe marking the end of any write command |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | 9 | Target byte address |
| mem_wr_ok | output | 1 | The byte at addr may be written |
| sr_wr_ok | output | 1 | A status write would be accepted |
| status | output | 8 | Status byte for readback |

## Verification
The bench probes both edges of each protected region: 0x17F and 0x180 for the top quarter, 0x0FF and 0x100 for the top half, and both ends of the array with full protection. A decoder that is off by one would let a write in just inside a region, or block one just outside it. The bench also checks the permits with the latch clear and with the pin low while bp is 11. A design that let either gate through would allow memory or status writes that are meant to be blocked.

Other cases are checked directly. A status write of 8'hFF must read back as 8'h0C. A status write refused by the pin must keep the old bp, and the latch must still drop at the end of that write. When set-enable and end-of-write arrive in the same cycle, the latch must end up 0. A design with the wrong priority would leave writes enabled by mistake.

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set_en,
  input  logic              cmd_clr_en,
  input  logic              cmd_wrsr,
  input  logic [7:0]        sr_wdata,
  input  logic              cmd_end_wr,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok,
  output logic [7:0]        status
);
  localparam int TOP = ADDR_W - 1;

  logic       wel;
  logic [1:0] bp;
  logic       in_prot;

  assign sr_wr_ok = wel & wp_n;

  always_comb begin
    unique case (bp)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = addr[TOP] & addr[TOP-1];
      2'b10:   in_prot = addr[TOP];
      default: in_prot = 1'b1;
    endcase
  end

  assign mem_wr_ok = sr_wr_ok & ~in_prot;
  assign status    = {4'b0000, bp, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wel <= 1'b0;
    else if (cmd_end_wr)      wel <= 1'b0;
    else if (cmd_clr_en)      wel <= 1'b0;
    else if (cmd_set_en)      wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bp <= 2'b00;
    else if (cmd_wrsr && sr_wr_ok) bp <= sr_wdata[3:2];
  end
endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_set_en,
  input logic       cmd_clr_en,
  input logic       cmd_wrsr,
  input logic       cmd_end_wr,
  input logic       wp_n,
  input logic       mem_wr_ok,
  input logic       sr_wr_ok,
  input logic [7:0] status
);
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end_wr |=> !status[1]); // R2

  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set_en && !cmd_clr_en && !cmd_end_wr) |=> status[1]); // R1

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:4] == 4'b0000) && !status[0]); // R3

  AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> (!mem_wr_ok && !sr_wr_ok)); // R5

  AST_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> (!mem_wr_ok && !sr_wr_ok)); // R6

  AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !mem_wr_ok); // R4

  AST_REFUSED_KEEPS_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !sr_wr_ok) |=> $stable(status[3:2])); // R8
endmodule

bind wr_guard wr_guard_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en),
  .cmd_wrsr(cmd_wrsr), .cmd_end_wr(cmd_end_wr), .wp_n(wp_n),
  .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok), .status(status)
);

// File: tb/test_wr_guard.sv
module test_wr_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_set_en = 1'b0, cmd_clr_en = 1'b0, cmd_wrsr = 1'b0, cmd_end_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic       wp_n = 1'b1;
  logic [8:0] addr = 9'h000;
  logic       mem_wr_ok, sr_wr_ok;
  logic [7:0] status;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wr_guard i_wr_guard (.*);

  // {bp[1:0], latch, wp_n, addr[8:0], exp_mem, exp_sr}
  localparam logic [14:0] VEC [16] = '{
    {2'b00,1'b0,1'b1,9'h000,1'b0,1'b0},
    {2'b00,1'b1,1'b0,9'h000,1'b0,1'b0},
    {2'b00,1'b1,1'b1,9'h000,1'b1,1'b1},
    {2'b00,1'b1,1'b1,9'h1FF,1'b1,1'b1},
    {2'b01,1'b1,1'b1,9'h17F,1'b1,1'b1},
    {2'b01,1'b1,1'b1,9'h180,1'b0,1'b1},
    {2'b01,1'b1,1'b1,9'h1FF,1'b0,1'b1},
    {2'b10,1'b1,1'b1,9'h0FF,1'b1,1'b1},
    {2'b10,1'b1,1'b1,9'h100,1'b0,1'b1},
    {2'b10,1'b1,1'b1,9'h17F,1'b0,1'b1},
    {2'b11,1'b1,1'b1,9'h000,1'b0,1'b1},
    {2'b11,1'b1,1'b1,9'h1FF,1'b0,1'b1},
    {2'b11,1'b1,1'b0,9'h000,1'b0,1'b0},
    {2'b01,1'b0,1'b1,9'h000,1'b0,1'b0},
    {2'b10,1'b1,1'b0,9'h0FF,1'b0,1'b0},
    {2'b00,1'b1,1'b1,9'h0AA,1'b1,1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 set, 1 clear, 2 status write, 3 end of write
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_set_en = 1'b1;
      1: cmd_clr_en = 1'b1;
      2: cmd_wrsr   = 1'b1;
      default: cmd_end_wr = 1'b1;
    endcase
    @(negedge clk);
    {cmd_set_en, cmd_clr_en, cmd_wrsr, cmd_end_wr} = 4'b0000;
  endtask

  task automatic load_bp(input logic [1:0] b);
    wp_n = 1'b1;
    pulse(0);
    sr_wdata = {4'b0000, b, 2'b00};
    pulse(2);
    pulse(3);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #1;
    check("R1 reset status", status, 8'h00);
    check("R5 reset permits", {6'b0, mem_wr_ok, sr_wr_ok}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 after reset", status, 8'h00);

    for (int i = 0; i < 16; i++) begin
      load_bp(VEC[i][14:13]);
      if (VEC[i][12]) pulse(0);
      wp_n = VEC[i][11];
      addr = VEC[i][10:2];
      #1;
      check($sformatf("R4/R5/R6/R7 vec %0d status", i), status,
            {4'b0000, VEC[i][14:13], VEC[i][12], 1'b0});
      check($sformatf("R4/R5/R6/R7 vec %0d permits", i),
            {6'b0, mem_wr_ok, sr_wr_ok}, {6'b0, VEC[i][1:0]});
    end

    // R1 disable clears
    load_bp(2'b00);
    pulse(0);
    check("R1 set", status, 8'h02);
    pulse(1);
    check("R1 disable", status, 8'h00);

    // R3 status write of FF loads only bits 3:2
    wp_n = 1'b1;
    pulse(0);
    sr_wdata = 8'hFF;
    pulse(2);
    check("R3 after FF write", status, 8'h0E);
    pulse(3);
    check("R3 after end", status, 8'h0C);

    // R8 refused status write (pin low)
    pulse(0);
    wp_n = 1'b0;
    sr_wdata = 8'h00;
    pulse(2);
    check("R8 bp kept pin low", status, 8'h0E);
    pulse(3);
    check("R8 latch cleared", status, 8'h0C);
    wp_n = 1'b1;

    // R8 refused status write (latch clear)
    pulse(2);
    check("R8 bp kept latch clear", status, 8'h0C);

    // R2 end of memory write clears latch
    load_bp(2'b00);
    pulse(0);
    pulse(3);
    check("R2 end clears", status, 8'h00);

    // R2 priority: set with end in same cycle
    @(negedge clk);
    cmd_set_en = 1'b1; cmd_end_wr = 1'b1;
    @(negedge clk);
    cmd_set_en = 1'b0; cmd_end_wr = 1'b0;
    check("R2 end beats set", status, 8'h00);

    // R2 priority: set with disable in same cycle
    @(negedge clk);
    cmd_set_en = 1'b1; cmd_clr_en = 1'b1;
    @(negedge clk);
    cmd_set_en = 1'b0; cmd_clr_en = 1'b0;
    check("R2 disable beats set", status, 8'h00);

    // R9 combinational address gating within a cycle, bp=01
    load_bp(2'b01);
    pulse(0);
    @(posedge clk);
    #1 addr = 9'h17F;
    #1 check("R9 below region", {7'b0, mem_wr_ok}, 8'h01);
    addr = 9'h180;
    #1 check("R9 inside region", {7'b0, mem_wr_ok}, 8'h00);
    wp_n = 1'b0; addr = 9'h000;
    #1 check("R9 pin drop", {7'b0, mem_wr_ok}, 8'h00);

    finish_run();
  end
endmodule